// File: doc/BRIEF.md
# System and Peripheral Clock Selector with Prescaler

This block builds the core clock and a slower peripheral clock for a small controller out of five free-running source clocks. These are an always-running internal fallback oscillator, an external input clock, a trimmed second oscillator, a crystal clock and a low-frequency (32 kHz class) clock. Two controls pick the source. A 2-bit oscillator-mode field names the preferred source. A core-select bit forces the fallback oscillator whatever the mode field holds. A 2-bit speed field then divides the selected clock by 1, 2, 4 or 8 before it leaves as `sys_clk`.

Every handover between sources runs through a per-source enable handshake. The old source is gated off on one of its own falling edges. Only after its release is confirmed does the new source get gated on, on one of its own falling edges. As a result, the output never carries a truncated high or low phase. Speed changes take effect only at the end of an output period.

A sleep request shuts the source off through the same handshake and stops `sys_clk`. An interrupt pulse restarts the block on the fallback oscillator. It stays there until software writes the core-select bit high and then releases it.

The control state machine runs on the fallback clock. Its states are PICK (enable the chosen source and wait for its acknowledge), RUN (settled), DROP (disable the old source before a change), NAP_DROP (disable the source before sleep) and NAP (asleep). Its transitions are: reset→PICK; PICK→RUN once the source acknowledges; RUN→NAP_DROP on a sleep request; RUN→DROP when the requested source differs from the running one; DROP→PICK once the old source has released; NAP_DROP→NAP once the source has released; NAP→PICK on a wake interrupt.

Top module: `sysclk_switch`

## Requirements
- R1: While `rst_n` is low, `switch_done` and `asleep` are low. After release the fallback source is enabled and `switch_done` rises. `sys_clk` then has the fallback period and `sub_clk` has 64 fallback periods.
- R2: With `core_int_sel`=1, `sys_clk` is taken from the fallback oscillator for every value of `osc_mode`.
- R3: With `core_int_sel`=0, `osc_mode` selects the source as follows: 2'b11 selects the external input, 2'b01 the trimmed oscillator, 2'b10 the crystal and 2'b00 the low-frequency clock.
- R4: `sub_clk` follows the settled source. It is the undivided selected clock divided by 64 when the fallback or trimmed source runs. It is the external input divided by 128, or the crystal divided by 128, when that source runs. It is the low-frequency clock itself when that source runs.
- R5: `speed` values 0, 1, 2 and 3 divide the selected source by 1, 2, 4 and 8. A new value takes effect at the end of the current output period.
- R6: On a source change, `switch_done` is low from the fallback cycle after the change is seen until the new source runs. At most one source is enabled at any time. No `sys_clk` phase is shorter than the smaller half-period of the old and new source.
- R7: A `speed` change produces no `sys_clk` phase shorter than half the source period.
- R8: A `sleep_req` seen in RUN disables the running source and raises `asleep`. `sys_clk` shows no rising edge until a wake.
- R9: A `wake_irq` pulse while asleep clears `asleep` and resumes on the fallback oscillator, even when `core_int_sel`=0. The block stays on the fallback oscillator until `core_int_sel`=1 has been seen in RUN. After that the mode field applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_int | input | 1 | Internal fallback oscillator; also clocks the control logic |
| clk_ext | input | 1 | External input clock |
| clk_trim | input | 1 | Trimmed second oscillator |
| clk_xtal | input | 1 | Crystal oscillator clock |
| clk_lf | input | 1 | Low-frequency clock |
| osc_mode | input | 2 | Preferred source: 11 ext, 01 trim, 10 crystal, 00 low-frequency |
| core_int_sel | input | 1 | 1 forces the fallback oscillator |
| speed | input | 2 | Division exponent: divide by 2^speed |
| sleep_req | input | 1 | Level request to stop the system clock |
| wake_irq | input | 1 | Wake interrupt, sampled on `clk_int` |
| sys_clk | output | 1 | Divided, glitch-free system clock |
| sub_clk | output | 1 | Peripheral clock |
| switch_done | output | 1 | High while a source runs settled |
| asleep | output | 1 | High while the system clock is stopped |

## Verification
The hardest situation to reach from the ports is a handover that starts while both source clocks sit in awkward phases. That is the case in which a plain multiplexer would emit a sliver pulse. The bench uses source periods of 6, 8, 14, 20 and 100 ns, which share few common multiples, so every handover lands at a different phase offset. A monitor records the length of every `sys_clk` phase across each change of source and speed and compares the shortest one to the bound for that pair. Sleep is entered from a non-fallback source, so that wake-up has to cross sources as well.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
    localparam int NSRC  = 5;
    localparam int SRC_W = 3;

    localparam logic [SRC_W-1:0] SRC_INT  = 3'd0;
    localparam logic [SRC_W-1:0] SRC_EXT  = 3'd1;
    localparam logic [SRC_W-1:0] SRC_TRIM = 3'd2;
    localparam logic [SRC_W-1:0] SRC_XTAL = 3'd3;
    localparam logic [SRC_W-1:0] SRC_LF   = 3'd4;

    typedef enum logic [2:0] {
        ST_PICK,
        ST_RUN,
        ST_DROP,
        ST_NAP_DROP,
        ST_NAP
    } sw_state_t;

    // Mode field to source index (encoding fixed by R3)
    function automatic logic [SRC_W-1:0] mode_to_src(input logic [1:0] m);
        logic [SRC_W-1:0] s;
        case (m)
            2'b11:   s = SRC_EXT;
            2'b01:   s = SRC_TRIM;
            2'b10:   s = SRC_XTAL;
            default: s = SRC_LF;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/sysclk_src_gate.sv
`timescale 1ns/1ps
// Per-source enable: request synchronised on the source's falling edge,
// enable reflected back to the control domain as an acknowledge.
module sysclk_src_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_src,
    input  logic clk_ctl,
    input  logic rst_n,
    input  logic req,
    output logic gated,
    output logic ack
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] en_pipe;
    logic [TOP:0] ack_pipe;

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en_pipe <= '0;
        else        en_pipe <= {en_pipe[TOP-1:0], req};
    end

    always_ff @(posedge clk_ctl or negedge rst_n) begin
        if (!rst_n) ack_pipe <= '0;
        else        ack_pipe <= {ack_pipe[TOP-1:0], en_pipe[TOP]};
    end

    assign gated = clk_src & en_pipe[TOP];
    assign ack   = ack_pipe[TOP];
endmodule

// File: rtl/sysclk_prescale.sv
`timescale 1ns/1ps
// Divide by 2^speed; a new ratio is adopted only at an output period boundary.
module sysclk_prescale #(
    parameter int SPEED_W = 2
) (
    input  logic               clk_in,
    input  logic               rst_n,
    input  logic [SPEED_W-1:0] speed,
    output logic               clk_out
);
    localparam int CNT_W = (1 << SPEED_W) - 1;

    logic [SPEED_W-1:0] ratio, ratio_nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt, last, half;
    logic               div_q;

    always_comb begin
        last      = CNT_W'((32'd1 << ratio) - 32'd1);
        cnt_nxt   = (cnt == last) ? '0 : cnt + CNT_W'(1);
        ratio_nxt = (cnt_nxt == '0) ? speed : ratio;
        half      = CNT_W'((32'd1 << ratio_nxt) >> 1);
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            ratio <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt_nxt;
            ratio <= ratio_nxt;
            div_q <= (ratio_nxt == '0) ? 1'b1 : (cnt_nxt < half);
        end
    end

    assign clk_out = (ratio == '0) ? clk_in : div_q;
endmodule

// File: rtl/sysclk_pow2_div.sv
`timescale 1ns/1ps
module sysclk_pow2_div #(
    parameter int LOG2_DIV = 6
) (
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_out
);
    logic [LOG2_DIV-1:0] cnt;

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + LOG2_DIV'(1);
    end

    assign clk_out = cnt[LOG2_DIV-1];
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int SPEED_W      = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int SUB_LOG2_SYS = 6,
    parameter int SUB_LOG2_OSC = 7
) (
    input  logic               rst_n,
    input  logic               clk_int,
    input  logic               clk_ext,
    input  logic               clk_trim,
    input  logic               clk_xtal,
    input  logic               clk_lf,
    input  logic [1:0]         osc_mode,
    input  logic               core_int_sel,
    input  logic [SPEED_W-1:0] speed,
    input  logic               sleep_req,
    input  logic               wake_irq,
    output logic               sys_clk,
    output logic               sub_clk,
    output logic               switch_done,
    output logic               asleep
);
    sw_state_t        st;
    logic [SRC_W-1:0] cur_src, target;
    logic             hold_int;
    logic [NSRC-1:0]  src_clk, src_req, src_ack, src_gated;
    logic             sys_pre, sys_sub, ext_sub, xtal_sub;

    assign src_clk = {clk_lf, clk_xtal, clk_trim, clk_ext, clk_int};
    assign target  = (core_int_sel || hold_int) ? SRC_INT : mode_to_src(osc_mode);

    // State register
    always_ff @(posedge clk_int or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_PICK;
            cur_src  <= SRC_INT;
            hold_int <= 1'b0;
        end else begin
            unique case (st)
                ST_PICK:
                    if (src_ack[cur_src]) st <= ST_RUN;
                ST_RUN: begin
                    if (core_int_sel) hold_int <= 1'b0;
                    if (sleep_req)                st <= ST_NAP_DROP;
                    else if (target != cur_src)   st <= ST_DROP;
                end
                ST_DROP:
                    if (!src_ack[cur_src]) begin
                        cur_src <= target;
                        st      <= ST_PICK;
                    end
                ST_NAP_DROP:
                    if (!src_ack[cur_src]) st <= ST_NAP;
                ST_NAP:
                    if (wake_irq) begin
                        cur_src  <= SRC_INT;
                        hold_int <= 1'b1;
                        st       <= ST_PICK;
                    end
                default: st <= ST_PICK;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        src_req     = '0;
        switch_done = 1'b0;
        asleep      = 1'b0;
        unique case (st)
            ST_PICK:     src_req[cur_src] = 1'b1;
            ST_RUN: begin
                src_req[cur_src] = 1'b1;
                switch_done      = 1'b1;
            end
            ST_DROP:     ;
            ST_NAP_DROP: ;
            ST_NAP:      asleep = 1'b1;
            default:     ;
        endcase
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        sysclk_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_src (src_clk[g]),
            .clk_ctl (clk_int),
            .rst_n   (rst_n),
            .req     (src_req[g]),
            .gated   (src_gated[g]),
            .ack     (src_ack[g])
        );
    end

    assign sys_pre = |src_gated;

    sysclk_prescale #(.SPEED_W(SPEED_W)) u_prescale (
        .clk_in  (sys_pre),
        .rst_n   (rst_n),
        .speed   (speed),
        .clk_out (sys_clk)
    );

    sysclk_pow2_div #(.LOG2_DIV(SUB_LOG2_SYS)) u_sub_sys (
        .clk_in (sys_pre), .rst_n (rst_n), .clk_out (sys_sub)
    );
    sysclk_pow2_div #(.LOG2_DIV(SUB_LOG2_OSC)) u_sub_ext (
        .clk_in (clk_ext), .rst_n (rst_n), .clk_out (ext_sub)
    );
    sysclk_pow2_div #(.LOG2_DIV(SUB_LOG2_OSC)) u_sub_xtal (
        .clk_in (clk_xtal), .rst_n (rst_n), .clk_out (xtal_sub)
    );

    always_comb begin
        case (cur_src)
            SRC_EXT:  sub_clk = ext_sub;
            SRC_XTAL: sub_clk = xtal_sub;
            SRC_LF:   sub_clk = clk_lf;
            default:  sub_clk = sys_sub;
        endcase
    end
endmodule

// File: rtl/sysclk_switch_chk.sv
`timescale 1ns/1ps
module sysclk_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       switch_done,
    input logic       asleep,
    input logic       wake_irq,
    input logic       core_int_sel,
    input logic [4:0] ack,
    input logic [2:0] cur
);
    a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    a_r1_done_acked: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> ack[cur]);

    a_r8_asleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (ack == 5'b0));

    a_r9_wake_int: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake_irq) |=> (!asleep && cur == 3'd0));

    a_r2_forced_int: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_done && $past(switch_done) && $past(core_int_sel)) |-> ack[0]);
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
    .clk          (clk_int),
    .rst_n        (rst_n),
    .switch_done  (switch_done),
    .asleep       (asleep),
    .wake_irq     (wake_irq),
    .core_int_sel (core_int_sel),
    .ack          (src_ack),
    .cur          (cur_src)
);

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
    localparam real P_INT = 8.0, P_EXT = 6.0, P_TRIM = 14.0, P_XTAL = 20.0, P_LF = 100.0;

    logic rst_n = 1'b0;
    logic clk_int = 1'b0, clk_ext = 1'b0, clk_trim = 1'b0, clk_xtal = 1'b0, clk_lf = 1'b0;
    logic [1:0] osc_mode = 2'b00;
    logic core_int_sel = 1'b1;
    logic [1:0] speed = 2'd0;
    logic sleep_req = 1'b0, wake_irq = 1'b0;
    logic sys_clk, sub_clk, switch_done, asleep;

    int checks = 0, fails = 0;
    int sys_edges = 0;
    real min_ph = 1.0e9, last_edge = 0.0;
    bit  mon_on = 1'b0, mon_fresh = 1'b1;

    always #4  clk_int  = ~clk_int;   // 125 MHz
    always #3  clk_ext  = ~clk_ext;
    always #7  clk_trim = ~clk_trim;
    always #10 clk_xtal = ~clk_xtal;
    always #50 clk_lf   = ~clk_lf;

    sysclk_switch uut (
        .rst_n(rst_n), .clk_int(clk_int), .clk_ext(clk_ext), .clk_trim(clk_trim),
        .clk_xtal(clk_xtal), .clk_lf(clk_lf), .osc_mode(osc_mode),
        .core_int_sel(core_int_sel), .speed(speed), .sleep_req(sleep_req),
        .wake_irq(wake_irq), .sys_clk(sys_clk), .sub_clk(sub_clk),
        .switch_done(switch_done), .asleep(asleep)
    );

    always @(posedge sys_clk) sys_edges++;

    always @(sys_clk) begin
        if (mon_on) begin
            if (!mon_fresh && ($realtime - last_edge) < min_ph) min_ph = $realtime - last_edge;
            mon_fresh = 1'b0;
            last_edge = $realtime;
        end
    end

    task automatic chk(input bit ok, input string tag, input real act, input real exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
        end
    endtask

    task automatic mon_start();
        min_ph = 1.0e9; mon_fresh = 1'b1; mon_on = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !switch_done; i++) @(posedge clk_int);
        @(negedge clk_int);
    endtask

    task automatic sys_period(output real p);
        real t0;
        repeat (3) @(posedge sys_clk);
        t0 = $realtime;
        @(posedge sys_clk);
        p = $realtime - t0;
    endtask

    task automatic sub_period(output real p);
        real t0;
        @(posedge sub_clk);
        t0 = $realtime;
        @(posedge sub_clk);
        p = $realtime - t0;
    endtask

    function automatic bit near(input real a, input real b);
        return (a - b < 0.01) && (b - a < 0.01);
    endfunction

    task automatic t_reset();
        real p;
        repeat (3) @(negedge clk_int);
        chk(!switch_done, "R1 done low in reset", real'(switch_done), 0.0);
        chk(!asleep, "R1 asleep low in reset", real'(asleep), 0.0);
        rst_n = 1'b1;
        wait_done();
        chk(switch_done, "R1 done after release", real'(switch_done), 1.0);
        sys_period(p);
        chk(near(p, P_INT), "R1 sys period", p, P_INT);
        sub_period(p);
        chk(near(p, 64.0 * P_INT), "R1 sub period", p, 64.0 * P_INT);
    endtask

    task automatic t_forced();
        real p;
        for (int m = 0; m < 4; m++) begin
            @(negedge clk_int);
            osc_mode = 2'(m);
            repeat (4) @(negedge clk_int);
            chk(switch_done, "R2 stays settled", real'(switch_done), 1.0);
            sys_period(p);
            chk(near(p, P_INT), "R2 forced fallback period", p, P_INT);
        end
    endtask

    task automatic go_mode(input logic [1:0] m, input real per, input real sub_exp, input real prev);
        real p, bound;
        @(negedge clk_int);
        mon_start();
        osc_mode = m; core_int_sel = 1'b0;
        repeat (2) @(negedge clk_int);
        chk(!switch_done, "R6 done low during change", real'(switch_done), 0.0);
        wait_done();
        sys_period(p);
        chk(near(p, per), "R3 mode source period", p, per);
        sub_period(p);
        sub_period(p);
        chk(near(p, sub_exp), "R4 sub clock period", p, sub_exp);
        bound = ((per < prev) ? per : prev) / 2.0;
        mon_on = 1'b0;
        chk(min_ph >= bound - 0.001, "R6 min phase on switch", min_ph, bound);
    endtask

    task automatic t_modes();
        go_mode(2'b11, P_EXT,  128.0 * P_EXT,  P_INT);
        go_mode(2'b01, P_TRIM, 64.0 * P_TRIM,  P_EXT);
        go_mode(2'b10, P_XTAL, 128.0 * P_XTAL, P_TRIM);
        go_mode(2'b00, P_LF,   P_LF,           P_XTAL);
    endtask

    task automatic t_divider();
        real p;
        @(negedge clk_int);
        core_int_sel = 1'b1;
        wait_done();
        for (int s = 1; s <= 4; s++) begin
            @(negedge clk_int);
            mon_start();
            speed = 2'(s % 4);
            sys_period(p);
            chk(near(p, P_INT * real'(1 << (s % 4))), "R5 divided period", p, P_INT * real'(1 << (s % 4)));
            mon_on = 1'b0;
            chk(min_ph >= P_INT / 2.0 - 0.001, "R7 min phase on speed change", min_ph, P_INT / 2.0);
        end
        @(negedge clk_int);
        osc_mode = 2'b10; core_int_sel = 1'b0; speed = 2'd2;
        wait_done();
        sys_period(p);
        chk(near(p, 4.0 * P_XTAL), "R5 crystal divided by 4", p, 4.0 * P_XTAL);
        @(negedge clk_int);
        speed = 2'd0;
    endtask

    task automatic t_sleep();
        real p;
        @(negedge clk_int);
        osc_mode = 2'b11; core_int_sel = 1'b0;
        wait_done();
        sleep_req = 1'b1;
        for (int i = 0; i < 5000 && !asleep; i++) @(negedge clk_int);
        chk(asleep, "R8 asleep raised", real'(asleep), 1.0);
        sleep_req = 1'b0;
        sys_edges = 0;
        repeat (60) @(negedge clk_int);
        chk(sys_edges == 0, "R8 no sys edges asleep", real'(sys_edges), 0.0);
        chk(asleep, "R8 still asleep", real'(asleep), 1.0);
        wake_irq = 1'b1;
        @(negedge clk_int);
        wake_irq = 1'b0;
        chk(!asleep, "R9 asleep cleared", real'(asleep), 0.0);
        wait_done();
        repeat (20) @(negedge clk_int);
        chk(switch_done, "R9 held on fallback", real'(switch_done), 1.0);
        sys_period(p);
        chk(near(p, P_INT), "R9 wake on fallback", p, P_INT);
        @(negedge clk_int);
        core_int_sel = 1'b1;
        repeat (3) @(negedge clk_int);
        core_int_sel = 1'b0;
        repeat (2) @(negedge clk_int);
        wait_done();
        sys_period(p);
        chk(near(p, P_EXT), "R9 reselect after release", p, P_EXT);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired R1-related run hung actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_forced();
        t_modes();
        t_divider();
        t_sleep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule